// File: doc/BRIEF.md
# Pause flow control command register

This block is the flow-control command register of an Ethernet MAC, together with the logic that turns flow-control events into pause-frame transmit requests. The host changes the control bits with a value bit and a bit map rather than with plain data. Each map bit written as 1 loads its control bit with the value bit. Each map bit written as 0 leaves its control bit alone. A 16-bit pause length field is written directly on every host write.

The block watches four things: a software command bit, an external flow-control pin (brought in through a synchronizer), the auto-negotiated pause capability of the link partner, and the duplex mode. From these it derives a pause-ability enable and a half-duplex back-pressure level. It also raises a pause-frame request that carries a 16-bit operand and stays pending until the transmitter acknowledges it. The loader that fills the register at start-up is represented only by its start and error strobes, and either strobe clears the register.

Top module: `pause_ctl_reg`

## Requirements
- R1: On a write, every bit set in `wr_data_i[22:16]` loads the matching control bit with `wr_data_i[23]`, and every bit left at 0 keeps its control bit. The control bits are: force pause at 20, negotiate pause at 19, fixed length at 18, pin enable at 17, and command at 16.
- R2: `wr_data_i[15:0]` is stored directly as the pause length on every write. Readback carries the control bits at 20:16 and the length at 15:0, and reads 0 at 31:21.
- R3: `pause_en_o` is 1 exactly when force pause is set, or when negotiate pause is set and `an_pause_i` is 1.
- R4: With fixed length clear, a 0-to-1 change of the command bit requests a pause frame with operand 16'hFFFF, and a 1-to-0 change requests one with operand 16'h0000.
- R5: With pin enable set and `full_duplex_i` high, a rising edge of the synchronized pin requests operand 16'hFFFF and a falling edge requests 16'h0000 (fixed length clear). With pin enable clear, the pin causes no request and no back pressure.
- R6: With fixed length set, rising edges of the command bit or of the enabled pin request a frame carrying the pause length, and falling edges request nothing.
- R7: `back_press_o` is high while pin enable is set, the synchronized pin is high and `full_duplex_i` is low. In half duplex, pin edges request no frame.
- R8: `pause_req_o` stays high with a stable operand until it is acknowledged with `pause_ack_i`. A newer event that comes before the acknowledge replaces the pending operand.
- R9: All register bits read 0 after reset and after a pulse on `ee_start_i` or on `ee_err_i`.
- R10: The pin passes through a two-stage synchronizer. A change on `fc_pin_i` reaches `back_press_o` after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 32 | Host write data (value bit, bit map, length) |
| rd_data_o | output | 32 | Register readback |
| ee_start_i | input | 1 | Loader start strobe, clears register |
| ee_err_i | input | 1 | Loader error strobe, clears register |
| fc_pin_i | input | 1 | Asynchronous flow-control pin |
| an_pause_i | input | 1 | Link partner supports pause (auto-negotiation result) |
| full_duplex_i | input | 1 | 1 = full duplex, 0 = half duplex |
| pause_en_o | output | 1 | Pause ability enable |
| pause_req_o | output | 1 | Pending pause-frame request |
| pause_opnd_o | output | 16 | Operand of the pending request |
| pause_ack_i | input | 1 | Transmitter accepts the pending request |
| back_press_o | output | 1 | Half-duplex back-pressure request |

## Verification
The bench builds the block with its defaults: a 16-bit length and a two-stage synchronizer. With these settings the two-edge pin latency can be checked cycle by cycle. They also make the XOFF operand (all ones) distinct from any programmed length used. The scoreboard withholds acknowledges while several events arrive. This makes operand replacement and the holding of a request observable at the ports.

// File: rtl/pause_ctl_pkg.sv
package pause_ctl_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned VAL_BIT  = 23;
  localparam int unsigned MAP_LO   = 16;
  localparam int unsigned MAP_HI   = 22;
  localparam int unsigned FORCE_B  = 20;
  localparam int unsigned NEG_B    = 19;
  localparam int unsigned FIXED_B  = 18;
  localparam int unsigned PINEN_B  = 17;
  localparam int unsigned CMD_B    = 16;

  typedef struct packed {
    logic force_pause;
    logic neg_pause;
    logic fixed_len;
    logic pin_en;
    logic cmd;
  } ctl_t;
endpackage

// File: rtl/pause_fc_sync.sv
module pause_fc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else if (g == 0) chain_q[g] <= d_i;
      else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pause_ctl_regs.sv
module pause_ctl_regs
  import pause_ctl_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             clr_i,
  output ctl_t             ctl_o,
  output logic [LEN_W-1:0] len_o,
  output logic [REG_W-1:0] rd_data_o
);
  localparam int unsigned PAD_W = REG_W - 21;

  ctl_t             ctl_q;
  logic [LEN_W-1:0] len_q;
  logic             unused_wr;

  assign unused_wr = ^{wr_data_i[REG_W-1:VAL_BIT+1], wr_data_i[MAP_HI:FORCE_B+1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      len_q <= '0;
    end else if (clr_i) begin
      ctl_q <= '0;
      len_q <= '0;
    end else if (wr_en_i) begin
      len_q <= wr_data_i[LEN_W-1:0];
      if (wr_data_i[FORCE_B]) ctl_q.force_pause <= wr_data_i[VAL_BIT];
      if (wr_data_i[NEG_B])   ctl_q.neg_pause   <= wr_data_i[VAL_BIT];
      if (wr_data_i[FIXED_B]) ctl_q.fixed_len   <= wr_data_i[VAL_BIT];
      if (wr_data_i[PINEN_B]) ctl_q.pin_en      <= wr_data_i[VAL_BIT];
      if (wr_data_i[CMD_B])   ctl_q.cmd         <= wr_data_i[VAL_BIT];
    end
  end

  assign ctl_o     = ctl_q;
  assign len_o     = len_q;
  assign rd_data_o = {{PAD_W{1'b0}}, ctl_q, {(16-LEN_W){1'b0}}, len_q};

  // R1: mapped bit takes the value bit
  p_map_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clr_i && wr_data_i[FORCE_B]) |=> (ctl_q.force_pause == $past(wr_data_i[VAL_BIT])));
  // R1: unmapped bit holds
  p_map_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clr_i && !wr_data_i[CMD_B]) |=> $stable(ctl_q.cmd));
  // R9
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (rd_data_o == '0));
endmodule

// File: rtl/pause_evt_gen.sv
module pause_evt_gen #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_i,
  input  logic             pin_i,
  input  logic             pin_en_i,
  input  logic             full_duplex_i,
  input  logic             fixed_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [LEN_W-1:0] opnd_o
);
  logic             cmd_q, pin_q, pend_q;
  logic [LEN_W-1:0] opnd_q, opnd_d;
  logic             pin_ok, rise_any, fall_any, evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      cmd_q <= cmd_i;
      pin_q <= pin_i;
    end
  end

  // pin edges only turn into frames in full duplex
  assign pin_ok   = pin_en_i & full_duplex_i;
  assign rise_any = (cmd_i & ~cmd_q) | (pin_ok & pin_i & ~pin_q);
  assign fall_any = (~cmd_i & cmd_q) | (pin_ok & ~pin_i & pin_q);
  assign evt      = rise_any | (fall_any & ~fixed_i);

  always_comb begin
    if (fixed_i)       opnd_d = len_i;
    else if (rise_any) opnd_d = '1;
    else               opnd_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      opnd_q <= '0;
    end else if (evt) begin
      pend_q <= 1'b1;
      opnd_q <= opnd_d;
    end else if (ack_i) begin
      pend_q <= 1'b0;
    end
  end

  assign req_o  = pend_q;
  assign opnd_o = opnd_q;

  // R8: pending request holds until acknowledged
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ack_i && !evt) |=> (pend_q && $stable(opnd_q)));
  // R8: acknowledge retires the request
  p_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && ack_i && !evt) |=> !pend_q);
  // R6: fixed mode falling edge alone makes no request
  p_fixed_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && fixed_i && !rise_any) |=> !pend_q);
endmodule

// File: rtl/pause_ctl_reg.sv
module pause_ctl_reg
  import pause_ctl_pkg::*;
#(
  parameter int unsigned LEN_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             ee_start_i,
  input  logic             ee_err_i,
  input  logic             fc_pin_i,
  input  logic             an_pause_i,
  input  logic             full_duplex_i,
  output logic             pause_en_o,
  output logic             pause_req_o,
  output logic [LEN_W-1:0] pause_opnd_o,
  input  logic             pause_ack_i,
  output logic             back_press_o
);
  ctl_t             ctl;
  logic [LEN_W-1:0] len;
  logic             pin_s;

  pause_fc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(fc_pin_i), .q_o(pin_s)
  );

  pause_ctl_regs #(.LEN_W(LEN_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .clr_i(ee_start_i | ee_err_i), .ctl_o(ctl), .len_o(len), .rd_data_o(rd_data_o)
  );

  pause_evt_gen #(.LEN_W(LEN_W)) u_evt (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(ctl.cmd), .pin_i(pin_s),
    .pin_en_i(ctl.pin_en), .full_duplex_i(full_duplex_i), .fixed_i(ctl.fixed_len),
    .len_i(len), .ack_i(pause_ack_i), .req_o(pause_req_o), .opnd_o(pause_opnd_o)
  );

  assign pause_en_o   = ctl.force_pause | (ctl.neg_pause & an_pause_i);
  assign back_press_o = ctl.pin_en & pin_s & ~full_duplex_i;

  // R7: no back pressure in full duplex
  p_bp_half_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    back_press_o |-> !full_duplex_i);
  // R5: disabled pin never presses back
  p_pin_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[PINEN_B] |-> !back_press_o);
endmodule

// File: tb/pause_ctl_reg_test.sv
module pause_ctl_reg_test;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, ee_start = 0, ee_err = 0, fc_pin = 0, an_pause = 0;
  logic        full_dup = 1, ack = 0;
  logic [31:0] wr_data = '0, rd_data;
  logic        pause_en, req, bp;
  logic [15:0] opnd;

  int n_cmp = 0, n_bad = 0;
  bit mon_hold = 0;
  bit done = 0;
  logic [15:0] exp_q[$];

  always #2.5 clk = ~clk;

  pause_ctl_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .ee_start_i(ee_start), .ee_err_i(ee_err),
    .fc_pin_i(fc_pin), .an_pause_i(an_pause), .full_duplex_i(full_dup),
    .pause_en_o(pause_en), .pause_req_o(req), .pause_opnd_o(opnd),
    .pause_ack_i(ack), .back_press_o(bp)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop expected operand on each request, then acknowledge
  initial begin
    forever begin
      @(negedge clk);
      if (!mon_hold && req) begin
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R4-R8 unexpected request actual=%h expected=none", opnd);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          if (opnd !== e) begin
            n_bad++;
            $display("FAIL R4-R8 operand actual=%h expected=%h", opnd, e);
          end
        end
        ack = 1;
        @(negedge clk);
        ack = 0;
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    // R9 reset state
    check("R9 reset rd", rd_data, 32'h0);
    check("R9 reset outs", {31'b0, req | bp | pause_en}, 32'h0);

    // R1/R2: value bit + map, reserved reads 0
    wr(32'hFF_F8_5A5A);  // value 1, map 22:19 (incl. reserved), garbage high byte
    check("R1 map set 20:19", rd_data, 32'h0018_5A5A);
    check("R2 len direct", {16'h0, rd_data[15:0]}, 32'h5A5A);
    wr(32'h0010_0011);   // value 0, clear only bit 20
    check("R1 map clear 20 hold 19", rd_data, 32'h0008_0011);

    // R3 pause enable
    an_pause = 0; idle(1);
    check("R3 neg no partner", {31'b0, pause_en}, 32'h0);
    an_pause = 1; idle(1);
    check("R3 neg partner", {31'b0, pause_en}, 32'h1);
    wr(32'h0008_0000); // clear neg
    check("R3 neg cleared", {31'b0, pause_en}, 32'h0);
    wr(32'h0090_0000); an_pause = 0; idle(1);
    check("R3 force", {31'b0, pause_en}, 32'h1);

    // R9 loader error clears
    @(negedge clk); ee_err = 1; @(negedge clk); ee_err = 0;
    check("R9 ee_err clear", rd_data, 32'h0);

    // R4 command edges
    exp_q.push_back(16'hFFFF);
    wr(32'h0081_0000);
    idle(6);
    exp_q.push_back(16'h0000);
    wr(32'h0001_0000);
    idle(6);
    check("R4 queue drained", exp_q.size(), 0);

    // R5 disabled pin ignored (full duplex)
    full_dup = 1;
    @(negedge clk); fc_pin = 1; idle(6);
    check("R5 pin off no bp", {31'b0, bp}, 32'h0);
    fc_pin = 0; idle(6);

    // R5 enabled pin edges in full duplex
    wr(32'h0082_0000);
    exp_q.push_back(16'hFFFF);
    @(negedge clk); fc_pin = 1; idle(8);
    check("R5 full dup no bp", {31'b0, bp}, 32'h0);
    exp_q.push_back(16'h0000);
    fc_pin = 0; idle(8);
    check("R5 queue drained", exp_q.size(), 0);

    // R7/R10 half duplex: back pressure, two-edge latency, no frames
    full_dup = 0;
    @(negedge clk); fc_pin = 1;
    @(negedge clk);
    check("R10 after one edge", {31'b0, bp}, 32'h0);
    @(negedge clk);
    check("R10 after two edges", {31'b0, bp}, 32'h1);
    idle(4);
    check("R7 bp held", {31'b0, bp}, 32'h1);
    fc_pin = 0; idle(4);
    check("R7 bp released", {31'b0, bp}, 32'h0);
    full_dup = 1;

    // R6 fixed length
    wr(32'h0084_1234);
    exp_q.push_back(16'h1234);
    wr(32'h0081_1234);
    idle(6);
    wr(32'h0001_1234);  // falling edge: no frame
    idle(6);
    exp_q.push_back(16'h00C3);
    wr(32'h0000_00C3);  // new length only
    @(negedge clk); fc_pin = 1; idle(8);
    fc_pin = 0; idle(8);
    check("R6 queue drained", exp_q.size(), 0);

    // R8 hold and replace
    wr(32'h0004_0000);  // fixed off
    mon_hold = 1;
    wr(32'h0081_0000);
    idle(5);
    check("R8 held req", {31'b0, req}, 32'h1);
    check("R8 held operand", {16'h0, opnd}, 32'hFFFF);
    wr(32'h0001_0000);
    idle(3);
    exp_q.push_back(16'h0000);
    mon_hold = 0;
    idle(6);
    check("R8 replaced drained", exp_q.size(), 0);
    check("R8 req retired", {31'b0, req}, 32'h0);

    // R9 loader start clears
    wr(32'h0094_0077);
    @(negedge clk); ee_start = 1; @(negedge clk); ee_start = 0;
    check("R9 ee_start clear", rd_data, 32'h0);
    idle(4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule